// File: doc/BRIEF.md
# I2C Master Command and Data Queue Port

This block is the byte-queue front end of an I2C master controller. Software sees one data/command port. A write to it queues an entry in a transmit command FIFO. Each entry is either a byte to send or a read request with no payload. A read from the same port pops the oldest byte from a receive FIFO. The bit engine that drives the bus sits on the other side: it pops commands when it is ready and pushes the bytes it receives.

Software can read the fill level of each FIFO and a constant word that reports both depths. It programs a threshold for each FIFO. The block compares the levels against these thresholds to produce level conditions for an interrupt unit. It also reports overflow and underflow as one-cycle event pulses. Both FIFOs are emptied when the bit engine reports an aborted transfer, and they are held empty while the block is disabled.

Top module: `i2c_cmdq_port`

## Requirements
- R1: A write to offset 0 with bit 8 clear queues the low 8 bits as a transmit byte. The engine sees that entry with `eng_cmd_rd`=0 and `eng_cmd_data` equal to the byte, in the order the entries were written.
- R2: A write to offset 0 with bit 8 set queues a read command. The engine sees `eng_cmd_rd`=1 and `eng_cmd_data`=0x00, whatever the low byte was.
- R3: A read of offset 0 returns the oldest received byte in bits 7:0, zero above, and removes that byte from the queue. Bytes come out in the order the engine pushed them.
- R4: Reads of offset 1 and offset 2 return the current transmit and receive entry counts. The range is 0 up to the depth.
- R5: A read of offset 6 returns the transmit depth minus one in bits 23:16 and the receive depth minus one in bits 15:8. All other bits read as zero.
- R6: Offsets 3 (transmit) and 4 (receive) hold thresholds that are writable and readable. Each threshold keeps only as many low bits as its level needs. `evt_tx_empty` is high while the transmit level is at or below its threshold. `evt_rx_full` is high while the receive level is above its threshold.
- R7: When `eng_abort` is high at a clock edge, both levels are zero after that edge. A port write or an engine push in the same cycle is discarded and raises no overflow.
- R8: A port write while the transmit FIFO holds the full depth is dropped. The level and the queued contents stay as they were, and `evt_tx_over` pulses for the one cycle after the write.
- R9: An engine push while the receive FIFO is full is dropped, and `evt_rx_over` pulses for the one cycle after the push.
- R10: A read of offset 0 while the receive FIFO is empty returns zero, and `evt_rx_under` pulses for the one cycle after the read.
- R11: Bit 0 of offset 5 is the enable, and reset clears it. While it is 0, both FIFOs are held empty, and port writes and engine pushes are discarded without an overflow event. Clearing it empties FIFOs that hold data.
- R12: After reset, both levels and both thresholds read 0, and all three event pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of offset 0 pops) |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of `reg_rd` |
| eng_cmd_valid | output | 1 | Transmit FIFO holds a command |
| eng_cmd_rd | output | 1 | Head command is a read request |
| eng_cmd_data | output | 8 | Head command byte (0 for a read request) |
| eng_cmd_pop | input | 1 | Engine takes the head command |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_abort | input | 1 | Transfer abort; empties both FIFOs |
| evt_tx_empty | output | 1 | Transmit level at or below its threshold |
| evt_rx_full | output | 1 | Receive level above its threshold |
| evt_tx_over | output | 1 | Pulse: a port write was dropped because the transmit FIFO was full |
| evt_rx_over | output | 1 | Pulse: an engine push was dropped because the receive FIFO was full |
| evt_rx_under | output | 1 | Pulse: the receive FIFO was read while empty |

## Verification
The bench fills each FIFO to exactly its depth and then pushes once more. A design that wrapped its pointers would overwrite the oldest entry, and the drain order would show it. A design that counted past the depth would report a level above the depth. The bench writes a read command with a nonzero low byte, which exposes a design that passes that byte to the engine. It reads an empty receive FIFO, which exposes stale data or a missing underflow pulse. It steps the levels across both thresholds by one entry, which exposes an off-by-one comparison. It applies an abort in the same cycle as a write, and it disables the block while both FIFOs hold data. A design that let the write survive, or that flagged a discarded write as an overflow, shows a nonzero level or a spurious pulse.

// File: rtl/i2c_cmdq_pkg.sv
// Package: register offsets and command-word layout shared by the queue port.
// Assumes a word-addressed register window of eight slots.
package i2c_cmdq_pkg;
    localparam int REG_AW     = 3;
    localparam int CMD_RD_BIT = 8;   // transmit word bit marking a read request
    localparam int CMD_W      = 9;   // read flag + byte

    typedef enum logic [REG_AW-1:0] {
        RA_DATA   = 3'd0,
        RA_TXLVL  = 3'd1,
        RA_RXLVL  = 3'd2,
        RA_TXTHR  = 3'd3,
        RA_RXTHR  = 3'd4,
        RA_ENABLE = 3'd5,
        RA_PARAM  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/i2c_cmdq_fifo.sv
// Synchronous FIFO with an entry count, a flush input and a head that can be read without popping.
// Assumes: a push while full and a pop while empty are ignored; flush takes priority over both.
module i2c_cmdq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == LVL_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign level   = count;
    assign head    = mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and count update; reset and flush both empty the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmdq_cfg.sv
// Configuration registers: the two level thresholds and the enable bit.
// Assumes the write strobe and the address are qualified by the caller; the upper threshold bits are dropped.
module i2c_cmdq_cfg
    import i2c_cmdq_pkg::*;
#(
    parameter int TX_LW = 4,
    parameter int RX_LW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [TX_LW-1:0]  tx_thr,
    output logic [RX_LW-1:0]  rx_thr,
    output logic              en
);
    // Capture register writes; reset clears thresholds and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= '0;
            rx_thr <= '0;
            en     <= 1'b0;
        end else if (wr) begin
            case (reg_addr_e'(addr))
                RA_TXTHR:  tx_thr <= wdata[TX_LW-1:0];
                RA_RXTHR:  rx_thr <= wdata[RX_LW-1:0];
                RA_ENABLE: en     <= wdata[0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmdq_evt.sv
// Registers single-cycle error conditions into one-cycle event pulses for the interrupt unit.
// Assumes every input is already a single-cycle condition.
module i2c_cmdq_evt #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    output logic [N-1:0] pulse
);
    // One register stage per event.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= '0;
        else        pulse <= cond;
    end
endmodule

// File: rtl/i2c_cmdq_port.sv
// Top level of the I2C master queue port. It joins the transmit command FIFO, the receive byte FIFO,
// the configuration registers and the event pulses behind one register window.
// Assumes at most one strobe (read or write) per cycle from the register side.
module i2c_cmdq_port
    import i2c_cmdq_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              eng_cmd_valid,
    output logic              eng_cmd_rd,
    output logic [7:0]        eng_cmd_data,
    input  logic              eng_cmd_pop,
    input  logic              eng_rx_push,
    input  logic [7:0]        eng_rx_data,
    input  logic              eng_abort,
    output logic              evt_tx_empty,
    output logic              evt_rx_full,
    output logic              evt_tx_over,
    output logic              evt_rx_over,
    output logic              evt_rx_under
);
    localparam int TX_LW = $clog2(TX_DEPTH + 1);
    localparam int RX_LW = $clog2(RX_DEPTH + 1);
    localparam logic [31:0] PARAM_WORD = {8'h00, 8'(TX_DEPTH - 1), 8'(RX_DEPTH - 1), 8'h00};

    logic             dp_wr, dp_rd, flush, en_q;
    logic [CMD_W-1:0] tx_word, tx_head;
    logic [TX_LW-1:0] tx_level, tx_thr;
    logic [RX_LW-1:0] rx_level, rx_thr;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]       rx_head;
    logic [2:0]       err_now, err_q;

    assign dp_wr = reg_wr && (reg_addr == RA_DATA);
    assign dp_rd = reg_rd && (reg_addr == RA_DATA);
    assign flush = eng_abort || !en_q;

    // Build the transmit word: a read request carries no payload.
    always_comb begin
        tx_word = '0;
        tx_word[CMD_RD_BIT] = reg_wdata[CMD_RD_BIT];
        if (!reg_wdata[CMD_RD_BIT]) tx_word[7:0] = reg_wdata[7:0];
    end

    i2c_cmdq_cfg #(.TX_LW(TX_LW), .RX_LW(RX_LW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .en(en_q)
    );

    i2c_cmdq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(dp_wr), .push_data(tx_word),
        .pop(eng_cmd_pop), .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    i2c_cmdq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(dp_rd), .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    // Error conditions of this cycle: tx overflow, rx overflow, rx underflow.
    always_comb begin
        err_now[0] = dp_wr && tx_full && !flush;
        err_now[1] = eng_rx_push && rx_full && !flush;
        err_now[2] = dp_rd && rx_empty;
    end

    i2c_cmdq_evt #(.N(3)) u_evt (.clk(clk), .rst_n(rst_n), .cond(err_now), .pulse(err_q));

    assign evt_tx_over  = err_q[0];
    assign evt_rx_over  = err_q[1];
    assign evt_rx_under = err_q[2];
    assign evt_tx_empty = (tx_level <= tx_thr);
    assign evt_rx_full  = (rx_level > rx_thr);

    assign eng_cmd_valid = !tx_empty;
    assign eng_cmd_rd    = tx_head[CMD_RD_BIT];
    assign eng_cmd_data  = tx_head[7:0];

    // Read-data multiplexer; an empty receive FIFO reads as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_DATA:   reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
            RA_TXLVL:  reg_rdata = 32'(tx_level);
            RA_RXLVL:  reg_rdata = 32'(rx_level);
            RA_TXTHR:  reg_rdata = 32'(tx_thr);
            RA_RXTHR:  reg_rdata = 32'(rx_thr);
            RA_ENABLE: reg_rdata = 32'(en_q);
            RA_PARAM:  reg_rdata = PARAM_WORD;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_cmdq_port_chk.sv
// Checker for the queue port: flush, overflow, underflow and level-bound properties.
// Assumes it is bound to i2c_cmdq_port and sees its internal levels and enable.
module i2c_cmdq_port_chk
    import i2c_cmdq_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_LW = $clog2(TX_DEPTH + 1),
    localparam int RX_LW = $clog2(RX_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              eng_abort,
    input logic              eng_rx_push,
    input logic              en_q,
    input logic [TX_LW-1:0]  tx_level,
    input logic [RX_LW-1:0]  rx_level,
    input logic              evt_tx_over,
    input logic              evt_rx_over,
    input logic              evt_rx_under
);
    p_abort_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> (tx_level == '0 && rx_level == '0));

    p_disabled_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (tx_level == '0 && rx_level == '0));

    p_tx_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_DATA && en_q && !eng_abort && tx_level == TX_LW'(TX_DEPTH))
        |=> (evt_tx_over && tx_level >= TX_LW'(TX_DEPTH - 1)));

    p_rx_over_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && en_q && !eng_abort && rx_level == RX_LW'(RX_DEPTH)) |=> evt_rx_over);

    p_under_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_DATA && rx_level == '0) |-> (reg_rdata == 32'd0));

    p_under_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_DATA && rx_level == '0) |=> evt_rx_under);

    p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= TX_LW'(TX_DEPTH)) && (rx_level <= RX_LW'(RX_DEPTH)));
endmodule

bind i2c_cmdq_port i2c_cmdq_port_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .eng_abort(eng_abort), .eng_rx_push(eng_rx_push), .en_q(en_q),
    .tx_level(tx_level), .rx_level(rx_level), .evt_tx_over(evt_tx_over),
    .evt_rx_over(evt_rx_over), .evt_rx_under(evt_rx_under)
);

// File: tb/i2c_cmdq_port_bench.sv
`timescale 1ns/1ps
// Bench for the queue port: directed corner cases, then seeded random traffic against a queue model.
module i2c_cmdq_port_bench;
    localparam int TXD = 8;
    localparam int RXD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        eng_cmd_valid, eng_cmd_rd;
    logic [7:0]  eng_cmd_data;
    logic        eng_cmd_pop = 0, eng_rx_push = 0, eng_abort = 0;
    logic [7:0]  eng_rx_data = 0;
    logic        evt_tx_empty, evt_rx_full, evt_tx_over, evt_rx_over, evt_rx_under;

    int n_run = 0, n_fail = 0;
    bit [8:0] m_tx[$];
    bit [7:0] m_rx[$];
    int m_txthr = 0, m_rxthr = 0;

    always #2.5 clk = ~clk;

    i2c_cmdq_port #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_i2c_cmdq_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_cmd_valid(eng_cmd_valid),
        .eng_cmd_rd(eng_cmd_rd), .eng_cmd_data(eng_cmd_data), .eng_cmd_pop(eng_cmd_pop),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_abort(eng_abort),
        .evt_tx_empty(evt_tx_empty), .evt_rx_full(evt_rx_full), .evt_tx_over(evt_tx_over),
        .evt_rx_over(evt_rx_over), .evt_rx_under(evt_rx_under)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All stimulus tasks start and end just after a falling edge.
    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic eng_pop(output logic v, output logic r, output logic [7:0] d);
        eng_cmd_pop = 1;
        #1 v = eng_cmd_valid; r = eng_cmd_rd; d = eng_cmd_data;
        @(posedge clk); @(negedge clk);
        eng_cmd_pop = 0;
    endtask

    task automatic eng_push(input logic [7:0] d);
        eng_rx_push = 1; eng_rx_data = d;
        @(posedge clk); @(negedge clk);
        eng_rx_push = 0;
    endtask

    function automatic logic [8:0] tx_expect(input logic [31:0] w);
        return w[8] ? 9'h100 : {1'b0, w[7:0]};
    endfunction

    // Model-side handling of a port write, with the overflow check.
    task automatic m_write(input logic [31:0] w, input string req);
        bit ov;
        ov = (m_tx.size() == TXD);
        reg_write(3'd0, w);
        if (!ov) m_tx.push_back(tx_expect(w));
        chk(req, evt_tx_over, ov);
    endtask

    task automatic m_pop(input string req);
        logic v, r; logic [7:0] d; bit [8:0] e;
        eng_pop(v, r, d);
        chk(req, v, m_tx.size() != 0);
        if (m_tx.size() != 0) begin
            e = m_tx.pop_front();
            chk(req, {r, d}, e);
        end
    endtask

    task automatic m_push(input logic [7:0] d, input string req);
        bit ov;
        ov = (m_rx.size() == RXD);
        eng_push(d);
        if (!ov) m_rx.push_back(d);
        chk(req, evt_rx_over, ov);
    endtask

    task automatic m_read(input string req);
        logic [31:0] d; bit un; bit [7:0] e;
        un = (m_rx.size() == 0);
        e = un ? 8'h00 : m_rx.pop_front();
        reg_read(3'd0, d);
        chk(req, d, {24'h0, e});
        chk(req, evt_rx_under, un);
    endtask

    task automatic check_levels(input string req);
        logic [31:0] d;
        reg_read(3'd1, d); chk(req, d, m_tx.size());
        reg_read(3'd2, d); chk(req, d, m_rx.size());
        chk(req, evt_tx_empty, m_tx.size() <= m_txthr);
        chk(req, evt_rx_full, m_rx.size() > m_rxthr);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12: reset state
        reg_read(3'd1, d); chk("R12 tx level", d, 0);
        reg_read(3'd2, d); chk("R12 rx level", d, 0);
        reg_read(3'd3, d); chk("R12 tx thr", d, 0);
        reg_read(3'd4, d); chk("R12 rx thr", d, 0);
        reg_read(3'd5, d); chk("R12 enable", d, 0);
        chk("R12 events", {evt_tx_over, evt_rx_over}, 0);

        // R11: disabled block discards writes and pushes without overflow
        reg_write(3'd0, 32'h55);
        chk("R11 no over", evt_tx_over, 0);
        eng_push(8'h11);
        chk("R11 no rx over", evt_rx_over, 0);
        check_levels("R11 disabled levels");

        reg_write(3'd5, 1);
        // R5: depths word
        reg_read(3'd6, d); chk("R5 param", d, {8'h0, 8'(TXD - 1), 8'(RXD - 1), 8'h0});

        // R1 and R2: data byte and read command with ignored payload
        m_write(32'h0A5, "R1 write");
        m_write(32'h1FF, "R2 write");
        check_levels("R4 levels after two");
        m_pop("R1 data entry");
        m_pop("R2 read command");

        // R8: fill to depth, then one more
        for (int i = 0; i < TXD; i++) m_write(32'(8'h30 + i), "R8 fill");
        m_write(32'h0EE, "R8 overflow");
        check_levels("R8 level held");
        for (int i = 0; i < TXD; i++) m_pop("R8 drain order");

        // R9 and R3: fill receive side past depth and drain in order
        for (int i = 0; i < RXD; i++) m_push(8'(8'h80 + i), "R9 fill");
        m_push(8'hCC, "R9 overflow");
        check_levels("R9 level held");
        for (int i = 0; i < RXD; i++) m_read("R3 drain order");

        // R10: empty read
        m_read("R10 underflow");

        // R6: threshold boundaries; upper bits dropped
        reg_write(3'd3, 32'hFFF3); m_txthr = 3;
        reg_read(3'd3, d); chk("R6 tx thr width", d, 3);
        reg_write(3'd4, 32'h2); m_rxthr = 2;
        for (int i = 0; i < 3; i++) m_write(32'(i), "R6 tx fill");
        chk("R6 tx at thr", evt_tx_empty, 1);
        m_write(32'h3, "R6 tx fill");
        chk("R6 tx above thr", evt_tx_empty, 0);
        for (int i = 0; i < 2; i++) m_push(8'(i), "R6 rx fill");
        chk("R6 rx at thr", evt_rx_full, 0);
        m_push(8'h7, "R6 rx fill");
        chk("R6 rx above thr", evt_rx_full, 1);

        // R7: abort together with a port write
        reg_wr = 1; reg_addr = 3'd0; reg_wdata = 32'h42; eng_abort = 1;
        @(posedge clk); @(negedge clk);
        reg_wr = 0; eng_abort = 0;
        chk("R7 no over on abort", evt_tx_over, 0);
        m_tx.delete(); m_rx.delete();
        check_levels("R7 flushed");

        // R11: disabling with data present empties both
        m_write(32'h9, "R11 refill");
        m_push(8'h9, "R11 refill");
        reg_write(3'd5, 0);
        @(negedge clk);
        m_tx.delete(); m_rx.delete();
        check_levels("R11 flushed by disable");
        reg_write(3'd5, 1);

        // Random traffic against the model
        for (int it = 0; it < 600; it++) begin
            case ($urandom_range(0, 4))
                0: m_write($urandom_range(0, 511), "R1 R2 R8 random write");
                1: m_pop("R1 random pop");
                2: m_push(8'($urandom), "R9 random push");
                3: m_read("R3 R10 random read");
                default: check_levels("R4 R6 random levels");
            endcase
        end
        check_levels("R4 final");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule